// File: doc/BRIEF.md
# Power-Gated SRAM Access Controller

This controller stands between a host's asynchronous, active-low memory strobes (chip select, write strobe, output strobe) and a byte-wide synchronous memory array. It samples the strobes on the system clock and turns them into read and write actions on the array. It drives the enable for the returned data and gives the array a single-cycle write pulse with a latched address and data byte. Every access is gated by a digital supply-good flag. Two battery-low flags are combined into one condition and sampled each time the supply returns. If both batteries are low at that moment, the second memory cycle after the supply returns is suppressed on purpose. Software can detect the weak battery by writing a byte and reading it back.

The sequencing is one state machine with five states. OFF covers the time while the supply is bad. IDLE waits for a cycle. READ covers chip select low with the write strobe high. WRITE covers chip select and write strobe both low. RECOVER waits until the write strobe has stayed high for a programmable number of clocks. The transitions are:
- OFF→IDLE when the supply is good.
- IDLE→READ when chip select is low and the write strobe is high.
- IDLE→WRITE when both are low.
- READ→IDLE when chip select rises.
- READ→WRITE when the write strobe falls during a read.
- WRITE→RECOVER on the first rising edge of either strobe. The byte is committed on this transition.
- RECOVER→IDLE after the write strobe has been high for the recovery count.
- Any state→OFF when the supply flag drops.

Top module: `pg_sram_ctl`

## Requirements
- R1: In a read (chip select low, write strobe high), `bus_oe` is 1 and `bus_dout` equals `mem_rdata` for the presented address only while `oe_n` is also low. Whenever `bus_oe` is 0, `bus_dout` is all zeros.
- R2: A write window opens once chip select and write strobe are both low, whichever of them fell last. This also holds when both fall together.
- R3: A write window closes on the first rising edge of chip select or write strobe. Each window produces exactly one single-cycle `mem_we` pulse. `mem_addr` and `mem_wdata` carry the `addr` and `din` values present when the window closed.
- R4: If the write strobe falls while a read has the outputs enabled, `bus_oe` goes to 0 and the cycle becomes a write.
- R5: While `pwr_good` is 0, no `mem_we` pulse is produced and `bus_oe` stays 0. A write window that the supply loss cuts short is discarded.
- R6: The battery-low condition is true only when both `batt_a_low` and `batt_b_low` are 1.
- R7: If the battery-low condition is true when `pwr_good` rises, the second memory cycle after that rise is inhibited. An inhibited read keeps `bus_oe` at 0 and `bus_dout` at zero. An inhibited write produces no `mem_we`. The first cycle and the third cycle behave normally.
- R8: After a write window closes, no new cycle starts until the write strobe has been high for TWR consecutive clocks. A low pulse on the write strobe during recovery restarts the count.
- R9: Every rising edge of `pwr_good` restarts the cycle count and samples the battery condition again.
- R10: While reset is asserted, `bus_oe`, `mem_we` and `bus_dout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output strobe, active low, asynchronous |
| addr | input | AW | Byte address from the host |
| din | input | DW | Write data from the host |
| pwr_good | input | 1 | Supply above the operating threshold |
| batt_a_low | input | 1 | First battery below its limit |
| batt_b_low | input | 1 | Second battery below its limit |
| mem_rdata | input | DW | Read data from the array at `mem_addr` |
| bus_oe | output | 1 | Enable for the read data onto the host bus |
| bus_dout | output | DW | Read data for the host, zero when disabled |
| mem_we | output | 1 | Single-cycle write pulse into the array |
| mem_addr | output | AW | Array address: latched write address during `mem_we`, else `addr` |
| mem_wdata | output | DW | Latched write data for the array |

## Verification
Every address of a small array is written, and the four orderings of the strobe edges rotate across the addresses: chip select or write strobe falling first, and chip select or write strobe rising first. A read-back of the whole array then shows whether the window framing drops, duplicates or mislatches any byte. Recovery is measured to the exact clock with and without a write-strobe glitch, which separates a real consecutive-high count from a simple delay. All four battery-flag combinations are swept over supply restarts, together with the first, second and third cycles and repeated restarts. Together these distinguish an AND from an OR of the flags, an off-by-one in the cycle counter, and a counter that does not re-arm.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_IDLE    = 3'd1,
        ST_READ    = 3'd2,
        ST_WRITE   = 3'd3,
        ST_RECOVER = 3'd4
    } psc_state_t;

    // Position of each strobe in the edge-detected vector
    localparam int unsigned STB_CE = 0;
    localparam int unsigned STB_WE = 1;

    // Cycle index (counted from 0) that is suppressed on a weak battery
    localparam int unsigned INHIBIT_IDX = 1;

endpackage

// File: rtl/psc_sync2.sv
module psc_sync2 #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/psc_strobe_edge.sv
module psc_strobe_edge #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);

    psc_sync2 #(.W(W), .RST_VAL({W{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (d),
        .q     (lvl)
    );

    for (genvar i = 0; i < W; i++) begin : g_edge
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q;
    end

endmodule

// File: rtl/psc_cycle_inhibit.sv
module psc_cycle_inhibit (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_rise,
    input  logic batt_low,
    input  logic cyc_start,
    output logic inhibit
);

    import psc_pkg::*;

    logic       armed_q;
    logic [1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            inhibit <= 1'b0;
        end else if (pwr_rise) begin
            armed_q <= batt_low;
            cnt_q   <= '0;
            inhibit <= 1'b0;
        end else if (cyc_start) begin
            inhibit <= armed_q && (cnt_q == 2'(INHIBIT_IDX));
            if (cnt_q != 2'(INHIBIT_IDX + 1))
                cnt_q <= cnt_q + 2'd1;
        end
    end

endmodule

// File: rtl/pg_sram_ctl.sv
module pg_sram_ctl #(
    parameter int unsigned AW  = 15,
    parameter int unsigned DW  = 8,
    parameter int unsigned TWR = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          pwr_good,
    input  logic          batt_a_low,
    input  logic          batt_b_low,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_oe,
    output logic [DW-1:0] bus_dout,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    import psc_pkg::*;

    localparam int unsigned RCW     = (TWR > 1) ? $clog2(TWR) : 1;
    localparam logic [RCW-1:0] RC_LAST = RCW'(TWR - 1);

    psc_state_t     state, nxt;
    logic [RCW-1:0] rc_q, rc_nxt;

    logic [1:0] cw_lvl, cw_rise;
    logic       ce_s, we_s, oe_s;
    logic       pwr_q, pwr_rise, batt_low;
    logic       cyc_start, inh, commit, close_win;
    logic [AW-1:0] waddr_q;

    // Strobe synchronisation
    psc_strobe_edge #(.W(2)) u_cw (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({we_n, ce_n}),
        .lvl   (cw_lvl),
        .rise  (cw_rise)
    );

    psc_sync2 #(.W(1), .RST_VAL(1'b1)) u_oe (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (oe_n),
        .q     (oe_s)
    );

    assign ce_s      = cw_lvl[STB_CE];
    assign we_s      = cw_lvl[STB_WE];
    assign close_win = cw_rise[STB_CE] | cw_rise[STB_WE];

    // Supply edge and battery condition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= 1'b0;
        else        pwr_q <= pwr_good;
    end

    assign pwr_rise  = pwr_good & ~pwr_q;
    assign batt_low  = batt_a_low & batt_b_low;
    assign cyc_start = (state == ST_IDLE) & pwr_good & ~ce_s;

    psc_cycle_inhibit u_inh (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_rise  (pwr_rise),
        .batt_low  (batt_low),
        .cyc_start (cyc_start),
        .inhibit   (inh)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            rc_q  <= '0;
        end else begin
            state <= nxt;
            rc_q  <= rc_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt    = state;
        rc_nxt = '0;
        if (!pwr_good) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    nxt = ST_IDLE;
                end
                ST_IDLE: begin
                    if (!ce_s) nxt = we_s ? ST_READ : ST_WRITE;
                end
                ST_READ: begin
                    if (ce_s)       nxt = ST_IDLE;
                    else if (!we_s) nxt = ST_WRITE;
                end
                ST_WRITE: begin
                    if (close_win) nxt = ST_RECOVER;
                end
                ST_RECOVER: begin
                    if (!we_s) begin
                        rc_nxt = '0;
                    end else if (rc_q == RC_LAST) begin
                        nxt = ST_IDLE;
                    end else begin
                        rc_nxt = rc_q + 1'b1;
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // Output logic
    always_comb begin
        commit = 1'b0;
        bus_oe = 1'b0;
        unique case (state)
            ST_READ:  bus_oe = pwr_good & ~ce_s & we_s & ~oe_s & ~inh;
            ST_WRITE: commit = pwr_good & close_win & ~inh;
            default: ;
        endcase
    end

    assign bus_dout = bus_oe ? mem_rdata : '0;

    // Write commit registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            waddr_q   <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= commit;
            if (commit) begin
                waddr_q   <= addr;
                mem_wdata <= din;
            end
        end
    end

    assign mem_addr = mem_we ? waddr_q : addr;

endmodule

// File: rtl/pg_sram_ctl_chk.sv
module pg_sram_ctl_chk #(
    parameter int unsigned DW  = 8,
    parameter int unsigned TWR = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pwr_good,
    input logic                 mem_we,
    input logic                 bus_oe,
    input logic [DW-1:0]        bus_dout,
    input logic                 inh,
    input logic                 we_s,
    input psc_pkg::psc_state_t  state
);

    import psc_pkg::*;

    localparam int unsigned HW = $clog2(TWR + 1) + 1;

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hi_cnt <= '0;
        else if (!we_s)              hi_cnt <= '0;
        else if (hi_cnt < HW'(TWR))  hi_cnt <= hi_cnt + 1'b1;
    end

    AST_WE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(pwr_good)); // R5

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (!bus_oe && !mem_we)); // R5

    AST_WE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R3

    AST_WE_NOT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(inh)); // R7

    AST_OE_NOT_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !mem_we); // R4

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_dout == '0)); // R1

    AST_RECOVER_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_RECOVER && state == ST_IDLE) |-> (hi_cnt >= HW'(TWR))); // R8

endmodule

bind pg_sram_ctl pg_sram_ctl_chk #(.DW(DW), .TWR(TWR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .mem_we   (mem_we),
    .bus_oe   (bus_oe),
    .bus_dout (bus_dout),
    .inh      (inh),
    .we_s     (we_s),
    .state    (state)
);

// File: tb/pg_sram_ctl_tb_top.sv
module pg_sram_ctl_tb_top;

    localparam int unsigned AW = 4;
    localparam int unsigned DW = 8;
    localparam int unsigned TWR = 3;
    localparam int unsigned NADDR = 1 << AW;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned WD_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic pwr_good = 1'b1, batt_a_low = 1'b0, batt_b_low = 1'b0;
    logic [DW-1:0] mem_rdata;
    logic bus_oe, mem_we;
    logic [DW-1:0] bus_dout, mem_wdata;
    logic [AW-1:0] mem_addr;

    int tests = 0;
    int fails = 0;
    int we_pulses = 0;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    logic [DW-1:0] arr [NADDR];
    logic [DW-1:0] exp_mem [NADDR];
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pg_sram_ctl #(.AW(AW), .DW(DW), .TWR(TWR)) dut_i (
        .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
        .addr (addr), .din (din), .pwr_good (pwr_good),
        .batt_a_low (batt_a_low), .batt_b_low (batt_b_low),
        .mem_rdata (mem_rdata), .bus_oe (bus_oe), .bus_dout (bus_dout),
        .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata)
    );

    // Array model
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NADDR; i++) arr[i] <= '0;
        end else if (mem_we) begin
            arr[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = arr[mem_addr];

    always @(negedge clk) begin
        if (mem_we) begin
            we_pulses++;
            cap_addr = mem_addr;
            cap_data = mem_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit ce_fall_first, input bit ce_rise_first);
        @(negedge clk);
        addr = a; din = d;
        if (ce_fall_first) ce_n = 1'b0; else we_n = 1'b0;
        waitn(2);
        ce_n = 1'b0; we_n = 1'b0;
        waitn(4);
        if (ce_rise_first) ce_n = 1'b1; else we_n = 1'b1;
        waitn(3);
        ce_n = 1'b1; we_n = 1'b1;
        waitn(TWR + 6);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit oe,
                           output logic oe_seen, output logic [DW-1:0] d_seen);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = ~oe;
        waitn(5);
        oe_seen = bus_oe; d_seen = bus_dout;
        ce_n = 1'b1; oe_n = 1'b1;
        waitn(4);
    endtask

    task automatic pcycle(input logic a, input logic b);
        @(negedge clk);
        batt_a_low = a; batt_b_low = b; pwr_good = 1'b0;
        waitn(3);
        pwr_good = 1'b1;
        waitn(4);
    endtask

    initial begin
        logic o;
        logic [DW-1:0] d;
        int p0;

        for (int i = 0; i < NADDR; i++) exp_mem[i] = '0;

        // R10 reset state
        waitn(3);
        check("R10 bus_oe in reset", bus_oe, 0);
        check("R10 mem_we in reset", mem_we, 0);
        check("R10 bus_dout in reset", bus_dout, 0);
        rst_n = 1'b1;
        waitn(4);

        // R2/R3 write sweep over all addresses and all four edge orderings
        for (int i = 0; i < NADDR; i++) begin
            logic [DW-1:0] v;
            v = DW'(i * 37 + 5);
            p0 = we_pulses;
            do_write(AW'(i), v, i[0], i[1]);
            exp_mem[i] = v;
            check("R3 one pulse per window", we_pulses - p0, 1);
            check("R3 latched address", cap_addr, i);
            check("R2 latched data", cap_data, v);
        end

        // R1 read-back of the whole array
        for (int i = 0; i < NADDR; i++) begin
            do_read(AW'(i), 1'b1, o, d);
            check("R1 read enable", o, 1);
            check("R1 read data", d, exp_mem[i]);
        end
        for (int i = 0; i < 3; i++) begin
            do_read(AW'(i), 1'b0, o, d);
            check("R1 oe high keeps outputs off", o, 0);
            check("R1 dout zero when off", d, 0);
        end

        // R4 write strobe falling during an enabled read
        p0 = we_pulses;
        @(negedge clk);
        addr = 4'd7; din = 8'h77; ce_n = 1'b0; oe_n = 1'b0;
        waitn(5);
        check("R4 outputs on before write strobe", bus_oe, 1);
        we_n = 1'b0;
        waitn(4);
        check("R4 outputs off after write strobe", bus_oe, 0);
        ce_n = 1'b1;
        waitn(3);
        we_n = 1'b1; oe_n = 1'b1;
        waitn(TWR + 6);
        exp_mem[7] = 8'h77;
        check("R4 write committed", we_pulses - p0, 1);
        do_read(4'd7, 1'b1, o, d);
        check("R4 read back", d, 8'h77);

        // R8 recovery timing, clean
        @(negedge clk);
        addr = 4'd5; din = 8'hA5; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        waitn(4);
        we_n = 1'b1;
        for (int i = 1; i <= TWR + 4; i++) begin
            @(negedge clk);
            if (i == TWR + 3) check("R8 no read before recovery", bus_oe, 0);
            if (i == TWR + 4) begin
                check("R8 read right after recovery", bus_oe, 1);
                check("R8 read data after recovery", bus_dout, 8'hA5);
            end
        end
        ce_n = 1'b1; oe_n = 1'b1;
        waitn(4);
        exp_mem[5] = 8'hA5;

        // R8 recovery restarted by a write-strobe glitch
        p0 = we_pulses;
        @(negedge clk);
        addr = 4'd6; din = 8'h5A; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        waitn(4);
        we_n = 1'b1;
        for (int i = 1; i <= TWR + 6; i++) begin
            @(negedge clk);
            if (i == 2) we_n = 1'b0;
            if (i == 3) we_n = 1'b1;
            if (i == TWR + 4) check("R8 glitch restarts recovery", bus_oe, 0);
            if (i == TWR + 6) check("R8 read after restarted recovery", bus_oe, 1);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        waitn(4);
        exp_mem[6] = 8'h5A;
        check("R8 glitch adds no write", we_pulses - p0, 1);

        // R5 supply low: accesses ignored
        @(negedge clk);
        pwr_good = 1'b0;
        waitn(3);
        p0 = we_pulses;
        do_write(4'd8, 8'hC3, 1'b1, 1'b1);
        check("R5 no write while supply low", we_pulses - p0, 0);
        do_read(4'd8, 1'b1, o, d);
        check("R5 no read while supply low", o, 0);
        check("R5 dout zero while supply low", d, 0);
        @(negedge clk);
        pwr_good = 1'b1;
        waitn(4);

        // R5 write window cut by supply loss
        p0 = we_pulses;
        @(negedge clk);
        addr = 4'd9; din = 8'h3C; ce_n = 1'b0; we_n = 1'b0;
        waitn(4);
        pwr_good = 1'b0;
        waitn(3);
        ce_n = 1'b1; we_n = 1'b1;
        waitn(3);
        pwr_good = 1'b1;
        waitn(4);
        check("R5 cut window discarded", we_pulses - p0, 0);
        do_read(4'd9, 1'b1, o, d);
        check("R5 cell unchanged", d, exp_mem[9]);

        // R6/R7 sweep over battery flag combinations: second cycle
        for (int c = 0; c < 4; c++) begin
            logic exp_on;
            exp_on = !(c[0] && c[1]);
            pcycle(c[0], c[1]);
            do_read(AW'(c), 1'b1, o, d);
            check("R7 first cycle normal", o, 1);
            do_read(AW'(c + 1), 1'b1, o, d);
            check("R6 second cycle enable vs flags", o, exp_on);
            check("R6 second cycle data vs flags", d, exp_on ? exp_mem[c + 1] : 8'h00);
            do_read(AW'(c + 2), 1'b1, o, d);
            check("R7 third cycle normal", d, exp_mem[c + 2]);
        end

        // R7/R9 re-armed inhibit discards a write in the second cycle
        pcycle(1'b1, 1'b1);
        do_read(4'd2, 1'b1, o, d);
        p0 = we_pulses;
        do_write(4'd2, 8'hEE, 1'b0, 1'b0);
        check("R9 re-armed inhibit drops write", we_pulses - p0, 0);
        do_read(4'd2, 1'b1, o, d);
        check("R9 cell kept after dropped write", d, exp_mem[2]);
        p0 = we_pulses;
        do_write(4'd2, 8'hEE, 1'b0, 1'b1);
        check("R7 later write commits", we_pulses - p0, 1);
        exp_mem[2] = 8'hEE;
        do_read(4'd2, 1'b1, o, d);
        check("R7 later write visible", d, 8'hEE);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule